// File: doc/BRIEF.md
# Ethernet Link Status LED Driver

This block turns the status of a 10/100 Ethernet PHY into three active-low indicator pins: one for line speed, one for link and traffic, and one for duplex. The link/traffic pin stays lit while a link is up. Each time transmit or receive traffic is seen, it goes dark for a fixed number of millisecond ticks. It then stays lit for at least the same number of ticks before it can go dark again. Traffic that arrives while the pin is dark, or during the lit hold that follows, is remembered and starts the next dark phase as soon as the hold ends.

Each pin can also serve as a general-purpose pin. A 12-bit configuration register, written with a single strobe, sets each pin as an input, a push-pull output or an open-drain output, or hands the pin to its indicator function. The pin-side interface is a data value plus an output enable per pin, so a pad can be inferred outside the block. An indicator pin is always open-drain: the enable is raised only when the pin pulls low. Pin levels are read back through a two-flop synchronizer. Timing is driven by a one-cycle tick input, normally one per millisecond, and a parameter sets the phase length in ticks.

Top module: `eth_led_gpio`

## Requirements
- R1: With its indicator enabled, pin 0 (speed) carries value 1 (released) only when `link_up` is 1, `speed_100` is 0 and `autoneg_busy` is 0. In every other case it carries value 0 (lit).
- R2: With its indicator enabled, pin 2 (duplex) carries value 0 when `link_up` and `full_duplex` are both 1, and value 1 otherwise.
- R3: Pin 1 (link/traffic) is lit (value 0) while a link is present and no dark phase is running. Whenever `link_up` is 0 at a clock edge, from the next cycle it is released (value 1) and any remembered traffic is discarded.
- R4: While pin 1 is steadily lit, traffic (`tx_act` or `rx_act` high at a clock edge) releases it from the next cycle, for exactly `PHASE_TICKS` ticks counted on `tick_ms`.
- R5: After a dark phase, pin 1 stays lit for exactly `PHASE_TICKS` ticks. Traffic seen during the dark phase or this hold is remembered and starts a new dark phase one cycle after the hold ends.
- R6: A pin whose indicator is enabled drives `pin_out` = indicator value and `pin_oe` = inverse of that value, so it never drives high.
- R7: A non-indicator pin in input mode (direction bit 0) has `pin_oe` = 0.
- R8: A non-indicator pin with direction bit 1 and open-drain bit 0 has `pin_oe` = 1 and `pin_out` = its data bit.
- R9: A non-indicator pin with direction bit 1 and open-drain bit 1 has `pin_out` = its data bit and `pin_oe` = 1 only when the data bit is 0.
- R10: `gpi_val` equals the value `pin_in` had two clock edges earlier.
- R11: After reset the configuration is all zero: every pin is an input with its indicator disabled, `pin_oe` is 0, `gpi_val` is 0, and the link/traffic sequence is idle.
- R12: When `cfg_we` is 1 at a clock edge, the register loads `cfg_wdata`. Bits [2:0] are the output data, [5:3] the direction, [8:6] open-drain and [11:9] indicator enable, with bit i of each field belonging to pin i. Indicator enable overrides the other three fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle timing tick (nominally 1 ms) |
| link_up | input | 1 | PHY reports a valid link |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | Link is full duplex |
| autoneg_busy | input | 1 | Auto-negotiation in progress |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 12 | Configuration write data |
| pin_in | input | 3 | Pad input levels |
| pin_out | output | 3 | Pad output values |
| pin_oe | output | 3 | Pad output enables |
| gpi_val | output | 3 | Synchronized pad input levels |

## Verification
A stuck or mis-stepped link/traffic sequence shows on pin 1 as a dark or lit phase that is one or more ticks too long or too short. It also shows as a missing dark phase after traffic that was remembered, visible within one tick period of the phase boundary. A pending flag that was not cleared shows as a spurious dark phase in the cycle after a link returns. A wrong mux or configuration bit shows on `pin_out` or `pin_oe` in the very next cycle. Comparing every pin against a reference model on every clock catches each of these at the first cycle it appears, including sequences where traffic lands on the exact edge where a phase ends.

// File: rtl/eth_led_gpio.sv
module eth_led_gpio #(
  parameter int unsigned PHASE_TICKS = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_ms,
  input  logic        link_up,
  input  logic        speed_100,
  input  logic        full_duplex,
  input  logic        autoneg_busy,
  input  logic        tx_act,
  input  logic        rx_act,
  input  logic        cfg_we,
  input  logic [11:0] cfg_wdata,
  input  logic [2:0]  pin_in,
  output logic [2:0]  pin_out,
  output logic [2:0]  pin_oe,
  output logic [2:0]  gpi_val
);

  localparam int unsigned CW = $clog2(PHASE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(PHASE_TICKS - 1);

  typedef enum logic [1:0] {LA_DARK, LA_LIT, LA_BLINK, LA_HOLD} la_st_t;

  la_st_t        la_st;
  logic [CW-1:0] ph_cnt;
  logic          la_pend;
  logic [2:0]    cfg_data, cfg_dir, cfg_od, cfg_led;
  logic [2:0]    gpi_s1, gpi_s2;
  logic [2:0]    led_val;
  logic          act;

  assign act = tx_act | rx_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_data <= '0;
      cfg_dir  <= '0;
      cfg_od   <= '0;
      cfg_led  <= '0;
    end else if (cfg_we) begin
      cfg_data <= cfg_wdata[2:0];
      cfg_dir  <= cfg_wdata[5:3];
      cfg_od   <= cfg_wdata[8:6];
      cfg_led  <= cfg_wdata[11:9];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpi_s1 <= '0;
      gpi_s2 <= '0;
    end else begin
      gpi_s1 <= pin_in;
      gpi_s2 <= gpi_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !link_up) begin
      la_st   <= LA_DARK;
      ph_cnt  <= '0;
      la_pend <= 1'b0;
    end else begin
      case (la_st)
        LA_DARK: la_st <= LA_LIT;
        LA_LIT: begin
          if (act || la_pend) begin
            la_st   <= LA_BLINK;
            ph_cnt  <= '0;
            la_pend <= 1'b0;
          end
        end
        LA_BLINK, LA_HOLD: begin
          if (act) la_pend <= 1'b1;
          if (tick_ms) begin
            if (ph_cnt == LAST) begin
              ph_cnt <= '0;
              la_st  <= (la_st == LA_BLINK) ? LA_HOLD : LA_LIT;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
        end
        default: la_st <= LA_DARK;
      endcase
    end
  end

  assign led_val[0] = link_up & ~speed_100 & ~autoneg_busy;
  assign led_val[1] = (la_st == LA_DARK) || (la_st == LA_BLINK);
  assign led_val[2] = ~(link_up & full_duplex);

  for (genvar i = 0; i < 3; i++) begin : g_pin
    assign pin_out[i] = cfg_led[i] ? led_val[i] : cfg_data[i];
    assign pin_oe[i]  = cfg_led[i] ? ~led_val[i]
                                   : (cfg_dir[i] & ~(cfg_od[i] & cfg_data[i]));
  end

  assign gpi_val = gpi_s2;

endmodule

// File: rtl/eth_led_gpio_chk.sv
module eth_led_gpio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       link_up,
  input logic       tx_act,
  input logic       rx_act,
  input logic [2:0] pin_in,
  input logic [2:0] pin_out,
  input logic [2:0] pin_oe,
  input logic [2:0] gpi_val,
  input logic [2:0] cfg_led,
  input logic [1:0] la_st,
  input logic       la_pend
);

  logic [1:0] up_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  AST_LED_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(cfg_led & pin_oe & pin_out))); // R6

  AST_NOLINK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (la_st == 2'd0 && !la_pend)); // R3

  AST_BLINK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && la_st == 2'd1 && (tx_act || rx_act)) |=> la_st == 2'd2); // R4

  AST_OFF_THEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && la_st == 2'd2) |=> (la_st == 2'd2 || la_st == 2'd3)); // R5

  AST_GPI_TWO_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd3) |-> gpi_val == $past(pin_in, 2)); // R10

endmodule

bind eth_led_gpio eth_led_gpio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .tx_act(tx_act), .rx_act(rx_act),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .gpi_val(gpi_val),
  .cfg_led(cfg_led), .la_st(la_st), .la_pend(la_pend)
);

// File: tb/eth_led_gpio_bench.sv
module eth_led_gpio_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, link_up = 1'b0, speed_100 = 1'b0, full_duplex = 1'b0;
  logic autoneg_busy = 1'b0, tx_act = 1'b0, rx_act = 1'b0, cfg_we = 1'b0;
  logic [11:0] cfg_wdata = '0;
  logic [2:0] pin_in = '0;
  logic [2:0] pin_out, pin_oe, gpi_val;

  eth_led_gpio #(.PHASE_TICKS(TK)) u_eth_led_gpio (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .link_up(link_up),
    .speed_100(speed_100), .full_duplex(full_duplex), .autoneg_busy(autoneg_busy),
    .tx_act(tx_act), .rx_act(rx_act), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .gpi_val(gpi_val)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  int m_ph = 0, m_cnt = 0;
  bit m_pend = 0;
  bit [11:0] m_cfg = '0;
  bit [2:0] m_gpi = '0;
  bit [2:0] gq[$];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (cfg_we) m_cfg = cfg_wdata;
    gq.push_back(pin_in);
    m_gpi = gq.pop_front();
    if (!link_up) begin
      m_ph = 0; m_cnt = 0; m_pend = 0;
    end else if (m_ph == 0) begin
      m_ph = 1;
    end else if (m_ph == 1) begin
      if (tx_act || rx_act || m_pend) begin m_ph = 2; m_cnt = 0; m_pend = 0; end
    end else begin
      if (tx_act || rx_act) m_pend = 1;
      if (tick_ms) begin
        m_cnt++;
        if (m_cnt == TK) begin m_cnt = 0; m_ph = (m_ph == 2) ? 3 : 1; end
      end
    end
  endtask

  task automatic compare();
    bit [2:0] e_led;
    e_led[0] = link_up && !speed_100 && !autoneg_busy;
    e_led[1] = (m_ph == 0) || (m_ph == 2);
    e_led[2] = !(link_up && full_duplex);
    for (int i = 0; i < 3; i++) begin
      bit d, dir, od, led, eo, ee;
      string rq;
      d = m_cfg[i]; dir = m_cfg[3+i]; od = m_cfg[6+i]; led = m_cfg[9+i];
      if (led) begin
        eo = e_led[i]; ee = !e_led[i];
        if (i == 0) rq = "R1";
        else if (i == 2) rq = "R2";
        else rq = (m_ph == 2) ? "R4" : (m_ph == 3) ? "R5" : "R3";
        chk(pin_out[i] == eo, rq, int'(pin_out[i]), int'(eo));
        chk(pin_oe[i] == ee, "R6", int'(pin_oe[i]), int'(ee));
      end else begin
        eo = d;
        if (!dir) begin ee = 0; rq = "R7"; end
        else if (!od) begin ee = 1; rq = "R8"; end
        else begin ee = !d; rq = "R9"; end
        chk(pin_oe[i] == ee, rq, int'(pin_oe[i]), int'(ee));
        if (dir) chk(pin_out[i] == eo, "R12", int'(pin_out[i]), int'(eo));
      end
    end
    chk(gpi_val == m_gpi, "R10", int'(gpi_val), int'(m_gpi));
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      cyc++;
      tick_ms = (cyc % 3 == 0);
    end
  endtask

  task automatic wr_cfg(bit [11:0] v);
    cfg_we = 1; cfg_wdata = v;
    run(1);
    cfg_we = 0;
  endtask

  task automatic pulse_tx();
    tx_act = 1; run(1); tx_act = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    gq.push_back(3'b000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R11: reset state
    chk(pin_oe == 3'b000, "R11", int'(pin_oe), 0);
    chk(gpi_val == 3'b000, "R11", int'(gpi_val), 0);
    run(2);

    wr_cfg(12'hE00);
    run(3);
    link_up = 1; speed_100 = 1; full_duplex = 1;
    run(6);
    pulse_tx();
    run(5);
    rx_act = 1; run(1); rx_act = 0;  // R5 remembered traffic
    run(40);
    rx_act = 1; run(60); rx_act = 0;
    run(40);
    speed_100 = 0; run(4);
    autoneg_busy = 1; run(4);
    autoneg_busy = 0; full_duplex = 0; run(4);
    pulse_tx(); run(3);
    link_up = 0; run(4);              // R3 drop during blink
    link_up = 1; run(8);
    pulse_tx(); run(14);
    tx_act = 1; run(1); tx_act = 0; run(30);

    wr_cfg({3'b000, 3'b000, 3'b111, 3'b101});  // R8
    run(4);
    wr_cfg({3'b000, 3'b110, 3'b111, 3'b101});  // R9
    run(4);
    wr_cfg({3'b000, 3'b000, 3'b010, 3'b111});  // R7
    for (int v = 0; v < 8; v++) begin
      pin_in = 3'(v); run(3);
    end

    wr_cfg({3'b010, 3'b101, 3'b100, 3'b001});
    for (int k = 0; k < 3000; k++) begin
      tx_act = ($urandom % 9) == 0;
      rx_act = ($urandom % 11) == 0;
      pin_in = 3'($urandom);
      if (($urandom % 97) == 0) link_up = ~link_up;
      if (($urandom % 53) == 0) speed_100 = ~speed_100;
      if (($urandom % 59) == 0) full_duplex = ~full_duplex;
      if (($urandom % 61) == 0) autoneg_busy = ~autoneg_busy;
      cfg_we = ($urandom % 211) == 0;
      cfg_wdata = 12'($urandom);
      run(1);
    end
    cfg_we = 0;
    finish_up();
  end
endmodule